// File: doc/BRIEF.md
# Branch and Move Condition Evaluator

This combinational unit decides whether a conditional branch, a conditional move or a conditional trap takes effect. A two-bit mode input picks among four forms. Three forms test a four-bit condition code against one of two four-bit flag groups: a 32-bit group and a 64-bit group. The fourth form compares a signed register value against zero.

Selector codes and condition codes that are reserved are never treated as don't-cares. They raise an illegal-instruction fault. In the conditional-move form, the selector codes that name floating-point condition groups raise a floating-point-disabled fault. Whenever either fault is raised, the taken and trap outputs stay low. The decode stage drives the unit from instruction fields and architectural flags, and reads the four outputs in the same cycle.

Top module: `cond_eval`

## Requirements
- R1: Mode encoding: 0 is branch, 1 is move, 2 is trap, 3 is register. Each flag group input is packed with N in bit 3, Z in bit 2, V in bit 1 and C in bit 0. In branch mode and trap mode, `grp_sel[1:0]` set to 0 selects `flags32`, set to 2 selects `flags64`, and `grp_sel[2]` is ignored.
- R2: In branch mode and trap mode, `grp_sel[1:0]` set to 1 or 3 raises `illegal` for every condition code.
- R3: Flag conditions 0 to 7 evaluate as follows: 0 never, 1 Z, 2 Z or (N xor V), 3 N xor V, 4 C or Z, 5 C, 6 N, 7 V.
- R4: Flag conditions 8 to 15 give the complement of conditions 0 to 7 respectively. Condition 8 is therefore always taken.
- R5: In move mode, `grp_sel` set to 4 selects `flags32` and `grp_sel` set to 6 selects `flags64`.
- R6: In move mode, `grp_sel` from 0 to 3 raises `fp_disabled`, and `illegal` stays low.
- R7: In move mode, `grp_sel` set to 5 or 7 raises `illegal`.
- R8: In trap mode, a passing condition raises `trap_req`, and `taken` stays low. In the other modes, `trap_req` is low.
- R9: In register mode, `cond[2:0]` tests `reg_val` as a two's-complement value: 1 tests equal to zero, 2 tests at most zero, 3 tests below zero, 5 tests nonzero, 6 tests above zero, 7 tests at least zero. In this mode `grp_sel`, `cond[3]` and both flag groups are ignored.
- R10: In register mode, `cond[2:0]` set to 0 or 4 raises `illegal` and is never taken.
- R11: Whenever `illegal` or `fp_disabled` is high, `taken` and `trap_req` are both low. The two faults are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode | input | 2 | Form: branch, move, trap or register |
| grp_sel | input | 3 | Flag-group selector |
| cond | input | 4 | Condition code (register mode uses bits 2:0) |
| flags32 | input | 4 | 32-bit flag group {N,Z,V,C} |
| flags64 | input | 4 | 64-bit flag group {N,Z,V,C} |
| reg_val | input | DATA_W | Register value compared against zero |
| taken | output | 1 | Branch or move takes effect |
| trap_req | output | 1 | Trap form condition passed |
| illegal | output | 1 | Illegal-instruction fault |
| fp_disabled | output | 1 | Floating-point-disabled fault |

## Verification
The bench targets the following corner cases:
- **Every condition code against single-flag and mixed flag patterns.** A wrong row or a swapped complement half would flip `taken` for exactly those codes.
- **Branch selector with bit 2 set.** A design that decodes all three selector bits here would fault where it should pick the 32-bit group.
- **Register extremes: zero, one, minus one, most positive and most negative.** An unsigned comparison would call the most negative value "above zero".
- **Reserved register conditions 0 and 4.** A design that treats them as don't-cares would either take the instruction or fail to fault.
- **Faulting codes combined with always-true conditions.** A design missing the fault gating would raise `taken` or `trap_req` alongside the fault.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;
   localparam int FLAG_W = 4;
   localparam int COND_W = 4;
   localparam int SEL_W  = 3;
   localparam int NUM_BASE = 1 << (COND_W - 1);

   typedef enum logic [1:0] {
      MODE_BRANCH = 2'd0,
      MODE_MOVE   = 2'd1,
      MODE_TRAP   = 2'd2,
      MODE_REG    = 2'd3
   } eval_mode_e;

   typedef struct packed {
      logic neg;
      logic zero;
      logic ovf;
      logic cry;
   } flags_t;
endpackage

// File: rtl/cc_group_select.sv
module cc_group_select
   import cond_eval_pkg::*;
(
   input  eval_mode_e         mode_i,
   input  logic [SEL_W-1:0]   sel_i,
   input  flags_t             grp32_i,
   input  flags_t             grp64_i,
   output flags_t             grp_o,
   output logic               bad_sel_o,
   output logic               fpd_o
);
   always_comb begin
      grp_o     = grp32_i;
      bad_sel_o = 1'b0;
      fpd_o     = 1'b0;
      unique case (mode_i)
         MODE_MOVE: begin
            if (!sel_i[2])       fpd_o     = 1'b1;
            else if (sel_i[0])   bad_sel_o = 1'b1;
            else if (sel_i[1])   grp_o     = grp64_i;
         end
         MODE_BRANCH, MODE_TRAP: begin
            if (sel_i[0])        bad_sel_o = 1'b1;
            else if (sel_i[1])   grp_o     = grp64_i;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/flag_cond_test.sv
module flag_cond_test
   import cond_eval_pkg::*;
(
   input  flags_t             flags_i,
   input  logic [COND_W-1:0]  cond_i,
   output logic               pass_o
);
   localparam int NUM_CODES = 2 * NUM_BASE;

   logic [NUM_BASE-1:0]  base;
   logic [NUM_CODES-1:0] table_v;

   always_comb begin
      base    = '0;
      base[1] = flags_i.zero;
      base[3] = flags_i.neg ^ flags_i.ovf;
      base[2] = flags_i.zero | base[3];
      base[4] = flags_i.cry | flags_i.zero;
      base[5] = flags_i.cry;
      base[6] = flags_i.neg;
      base[7] = flags_i.ovf;
   end

   for (genvar k = 0; k < NUM_CODES; k++) begin : g_code
      if (k < NUM_BASE) begin : g_pos
         assign table_v[k] = base[k];
      end else begin : g_neg
         assign table_v[k] = ~base[k-NUM_BASE];
      end
   end

   assign pass_o = table_v[cond_i];
endmodule

// File: rtl/reg_zero_test.sv
module reg_zero_test #(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] val_i,
   input  logic [2:0]        rcond_i,
   output logic              pass_o,
   output logic              bad_o
);
   if (DATA_W < 2) begin : g_width_check
      $error("reg_zero_test: DATA_W must be at least 2");
   end

   logic is_zero;
   logic is_neg;
   logic hit;

   assign is_zero = (val_i == '0);
   assign is_neg  = val_i[DATA_W-1];

   always_comb begin
      unique case (rcond_i[1:0])
         2'd1:    hit = is_zero;
         2'd2:    hit = is_zero | is_neg;
         2'd3:    hit = is_neg;
         default: hit = 1'b0;
      endcase
   end

   assign bad_o  = (rcond_i[1:0] == 2'd0);
   assign pass_o = !bad_o && (rcond_i[2] ? !hit : hit);
endmodule

// File: rtl/cond_eval.sv
module cond_eval
   import cond_eval_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [1:0]        mode,
   input  logic [2:0]        grp_sel,
   input  logic [3:0]        cond,
   input  logic [3:0]        flags32,
   input  logic [3:0]        flags64,
   input  logic [DATA_W-1:0] reg_val,
   output logic              taken,
   output logic              trap_req,
   output logic              illegal,
   output logic              fp_disabled
);
   eval_mode_e mode_e;
   flags_t     grp;
   logic       sel_bad, sel_fpd, flag_pass, reg_pass, reg_bad;
   logic       is_reg, pass, fault;

   assign mode_e = eval_mode_e'(mode);
   assign is_reg = (mode_e == MODE_REG);

   cc_group_select u_sel (
      .mode_i    (mode_e),
      .sel_i     (grp_sel),
      .grp32_i   (flags_t'(flags32)),
      .grp64_i   (flags_t'(flags64)),
      .grp_o     (grp),
      .bad_sel_o (sel_bad),
      .fpd_o     (sel_fpd)
   );

   flag_cond_test u_flag (
      .flags_i (grp),
      .cond_i  (cond),
      .pass_o  (flag_pass)
   );

   reg_zero_test #(.DATA_W(DATA_W)) u_reg (
      .val_i   (reg_val),
      .rcond_i (cond[2:0]),
      .pass_o  (reg_pass),
      .bad_o   (reg_bad)
   );

   assign fp_disabled = !is_reg && sel_fpd;
   assign illegal     = is_reg ? reg_bad : sel_bad;
   assign fault       = illegal | fp_disabled;
   assign pass        = (is_reg ? reg_pass : flag_pass) && !fault;
   assign trap_req    = pass && (mode_e == MODE_TRAP);
   assign taken       = pass && (mode_e != MODE_TRAP);
endmodule

// File: rtl/cond_eval_checker.sv
module cond_eval_checker #(
   parameter int DATA_W = 64
) (
   input logic [1:0]        mode,
   input logic [2:0]        grp_sel,
   input logic [3:0]        cond,
   input logic [DATA_W-1:0] reg_val,
   input logic              taken,
   input logic              trap_req,
   input logic              illegal,
   input logic              fp_disabled
);
   always_comb begin
      assert_fault_excl_R11: assert (!(illegal && fp_disabled));
      assert_fault_gates_R11: assert (!(illegal || fp_disabled) || (!taken && !trap_req));
      assert_trap_only_R8: assert (mode == 2'd2 || !trap_req);
      assert_trap_no_take_R8: assert (mode != 2'd2 || !taken);
      assert_reg_reserved_R10: assert (!(mode == 2'd3 && cond[1:0] == 2'd0) || (illegal && !taken));
      assert_move_fpd_R6: assert (!(mode == 2'd1 && !grp_sel[2]) || fp_disabled);
      assert_bad_sel_R2: assert (!((mode == 2'd0 || mode == 2'd2) && grp_sel[0]) || illegal);
      assert_reg_eq_R9: assert (!(mode == 2'd3 && cond[2:0] == 3'd1 && reg_val == '0) || taken);
   end
endmodule

bind cond_eval cond_eval_checker #(.DATA_W(DATA_W)) u_chk (
   .mode        (mode),
   .grp_sel     (grp_sel),
   .cond        (cond),
   .reg_val     (reg_val),
   .taken       (taken),
   .trap_req    (trap_req),
   .illegal     (illegal),
   .fp_disabled (fp_disabled)
);

// File: tb/cond_eval_bench.sv
`timescale 1ns/1ps
module cond_eval_bench;
   localparam int DW = 64;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2.5 clk = ~clk;

   logic [1:0]    mode;
   logic [2:0]    grp_sel;
   logic [3:0]    cond;
   logic [3:0]    flags32, flags64;
   logic [DW-1:0] reg_val;
   logic          taken, trap_req, illegal, fp_disabled;

   int total = 0;
   int bad   = 0;

   cond_eval #(.DATA_W(DW)) u_cond_eval (
      .mode(mode), .grp_sel(grp_sel), .cond(cond),
      .flags32(flags32), .flags64(flags64), .reg_val(reg_val),
      .taken(taken), .trap_req(trap_req), .illegal(illegal),
      .fp_disabled(fp_disabled)
   );

   function automatic logic ref_base(int c, logic [3:0] f);
      logic n, z, v, cy;
      n = f[3]; z = f[2]; v = f[1]; cy = f[0];
      case (c)
         1: return z;
         2: return z || (n != v);
         3: return n != v;
         4: return cy || z;
         5: return cy;
         6: return n;
         7: return v;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic ref_flag(int c, logic [3:0] f);
      return (c >= 8) ? !ref_base(c - 8, f) : ref_base(c, f);
   endfunction

   task automatic chk(string req, logic [3:0] exp);
      logic [3:0] act;
      act = {taken, trap_req, illegal, fp_disabled};
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s mode=%0d sel=%0d cond=%0d {taken,trap,ill,fpd} actual=%b expected=%b",
                  req, mode, grp_sel, cond, act, exp);
      end
   endtask

   task automatic apply(logic [1:0] m, logic [2:0] s, logic [3:0] c,
                        logic [3:0] f32, logic [3:0] f64, logic [DW-1:0] v);
      @(negedge clk);
      mode = m; grp_sel = s; cond = c; flags32 = f32; flags64 = f64; reg_val = v;
      #1;
   endtask

   task automatic t_reset();
      apply(2'd0, 3'd0, 4'd0, 4'h0, 4'h0, '0);
      chk("R3 reset idle", 4'b0000);
   endtask

   task automatic t_branch();
      logic [3:0] pats [7] = '{4'h0, 4'hF, 4'h8, 4'h4, 4'h2, 4'h1, 4'hA};
      foreach (pats[p]) begin
         for (int c = 0; c < 16; c++) begin
            apply(2'd0, 3'd0, 4'(c), pats[p], ~pats[p], '0);
            chk(c < 8 ? "R3 branch flags32" : "R4 branch complement",
                {ref_flag(c, pats[p]), 3'b000});
            apply(2'd0, 3'd2, 4'(c), pats[p], ~pats[p], '0);
            chk("R1 branch flags64", {ref_flag(c, ~pats[p]), 3'b000});
            apply(2'd0, 3'd4, 4'(c), pats[p], ~pats[p], '0);
            chk("R1 sel bit2 ignored", {ref_flag(c, pats[p]), 3'b000});
         end
      end
   endtask

   task automatic t_branch_bad();
      for (int s = 1; s < 8; s += 2) begin
         apply(2'd0, 3'(s), 4'd8, 4'hF, 4'hF, '0);
         chk("R2 R11 branch reserved sel", 4'b0010);
      end
   endtask

   task automatic t_move();
      for (int c = 0; c < 16; c++) begin
         apply(2'd1, 3'd4, 4'(c), 4'h5, 4'hA, '0);
         chk("R5 move flags32", {ref_flag(c, 4'h5), 3'b000});
         apply(2'd1, 3'd6, 4'(c), 4'h5, 4'hA, '0);
         chk("R5 move flags64", {ref_flag(c, 4'hA), 3'b000});
      end
      for (int s = 0; s < 4; s++) begin
         apply(2'd1, 3'(s), 4'd8, 4'hF, 4'hF, '0);
         chk("R6 R11 move fp group", 4'b0001);
      end
      apply(2'd1, 3'd5, 4'd8, 4'hF, 4'hF, '0);
      chk("R7 move sel 5", 4'b0010);
      apply(2'd1, 3'd7, 4'd8, 4'hF, 4'hF, '0);
      chk("R7 move sel 7", 4'b0010);
   endtask

   task automatic t_trap();
      for (int c = 0; c < 16; c++) begin
         apply(2'd2, 3'd0, 4'(c), 4'h6, 4'h9, '0);
         chk("R8 trap flags32", {1'b0, ref_flag(c, 4'h6), 2'b00});
         apply(2'd2, 3'd2, 4'(c), 4'h6, 4'h9, '0);
         chk("R8 trap flags64", {1'b0, ref_flag(c, 4'h9), 2'b00});
      end
      apply(2'd2, 3'd1, 4'd8, 4'hF, 4'hF, '0);
      chk("R2 trap sel 1", 4'b0010);
      apply(2'd2, 3'd3, 4'd8, 4'hF, 4'hF, '0);
      chk("R2 trap sel 3", 4'b0010);
   endtask

   task automatic t_reg();
      logic [DW-1:0] vals [7] = '{64'd0, 64'd1, {DW{1'b1}}, {1'b0, {(DW-1){1'b1}}},
                                 {1'b1, {(DW-1){1'b0}}}, 64'd5, -64'sd5};
      foreach (vals[i]) begin
         for (int c = 0; c < 16; c++) begin
            logic signed [DW-1:0] sv;
            logic e;
            sv = $signed(vals[i]);
            case (c % 8)
               1: e = (sv == 0);
               2: e = (sv <= 0);
               3: e = (sv < 0);
               5: e = (sv != 0);
               6: e = (sv > 0);
               7: e = (sv >= 0);
               default: e = 1'b0;
            endcase
            apply(2'd3, 3'(c), 4'(c), 4'hF, 4'h0, vals[i]);
            if (c % 4 == 0) chk("R10 reg reserved cond", 4'b0010);
            else            chk("R9 reg signed test", {e, 3'b000});
         end
      end
   endtask

   initial begin
      mode = '0; grp_sel = '0; cond = '0; flags32 = '0; flags64 = '0; reg_val = '0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      t_reset();
      t_branch();
      t_branch_bad();
      t_move();
      t_trap();
      t_reg();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule